// File: doc/BRIEF.md
# Signature Path Lookahead Prefetcher

This block watches demand accesses, each given as a page number and a block offset within the page, and learns how the offsets inside each page move. The recent offset steps of a page are folded into a short signature. A shared pattern table, indexed by that signature, counts which step tends to come next. After every accepted access the block walks forward along the most likely path. At each step it predicts a delta, folds the delta into a copy of the signature and looks the table up again. Each predicted block is sent out as a prefetch address.

Every step has a confidence: the winning delta's count divided by the entry's signature count. The confidence of the whole path is the product of the step confidences. The walk ends when that product falls below a quarter, when eight prefetches have been issued, or when the next target would leave the page. In the last case the block does not issue the target. It parks the signature and the wrapped offset in a small global history. A later first touch of a new page at that offset then starts from the parked signature and does not begin cold.

The block accepts one access per idle cycle. It then walks until the walk ends, issuing at most one prefetch per cycle, and holds each request while the consumer stalls.

Top module: `spp_prefetcher`

## Requirements
- R1: After reset `acc_ready` is 1, `pf_valid` is 0, and every table is empty.
- R2: Each page keeps the last offset and a 12-bit signature in a direct-mapped table indexed by the low 4 page bits and tagged with the full page. An access whose delta (new offset minus last offset, as 7-bit two's complement) is zero leaves the signature and the pattern table unchanged.
- R3: A nonzero delta trains the pattern entry of the old signature. The entry has 4 slots, each with a delta and a 4-bit counter, plus a 4-bit signature counter. A slot already holding the delta (counter nonzero, lowest index first) is incremented. Otherwise the slot with the smallest counter (lowest index on ties) takes the delta with count 1. The signature counter is incremented. If the signature counter or the hit slot counter is already 15, all five counters of the entry are halved first.
- R4: The new signature is ((sig << 3) XOR delta) truncated to 12 bits, with the delta zero-extended. The pattern table is indexed by the low 6 signature bits.
- R5: A walk step uses the slot with the largest counter (lowest index on ties). Its confidence is counter*256/signature-counter. The path confidence starts at 256 and becomes (path*step)>>8. The step goes ahead only if the entry has a nonzero slot and the new path confidence is at least 64.
- R6: A step whose target (current offset plus signed delta) lies in 0..63 drives `pf_valid` with `pf_addr` = {page, target}. The request stays unchanged until `pf_ready`, and then the walk advances to that target.
- R7: A walk issues at most 8 prefetches.
- R8: A step whose target leaves the page issues nothing. It writes the advanced signature and the target modulo 64 into a 4-entry global history, filled round-robin, and ends the walk.
- R9: An access that misses the signature table and whose offset equals the offset of a valid history entry (lowest index first) adopts that entry's signature and invalidates the entry. With no such entry the signature starts at 0. Every accepted access then starts a walk from its resulting signature and offset.
- R10: `acc_ready` is 1 only when no walk is active. An accepted access always lowers it in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Demand access present |
| acc_page | input | 20 | Page number of the access |
| acc_off | input | 6 | Block offset within the page |
| acc_ready | output | 1 | Block idle, access taken this cycle |
| pf_valid | output | 1 | Prefetch request present |
| pf_addr | output | 26 | Prefetch block address {page, offset} |
| pf_ready | input | 1 | Consumer takes the prefetch request |

## Verification
The bench targets a steady stride that converges to a fixed signature and must run exactly eight deep; a design that miscounts depth issues seven or nine requests. Near the top of a page a walk must stop at the boundary and park its signature. A fresh page touched at the wrapped offset must then replay the stride at once, which a broken history lookup would miss. Stalls during a walk, repeated offsets, aliased pages that evict each other, and long random runs that saturate and halve counters are all compared every cycle against a behavioural model. A wrong tie rule, a wrong halving point or wrong confidence arithmetic shows up as a missing, extra or misplaced prefetch.

// File: rtl/spp_pkg.sv
// Shared types of the signature path prefetcher.
package spp_pkg;
    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;
endpackage

// File: rtl/spp_sig_table.sv
// Per-page history: last offset and signature.
// Direct-mapped on the low page bits and tagged with the full page.
// Assumes the write uses the page that is being looked up in the same cycle.
module spp_sig_table #(
    parameter int PAGE_W = 20,
    parameter int OFF_W  = 6,
    parameter int SIG_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] lk_page,
    output logic              lk_hit,
    output logic [OFF_W-1:0]  lk_off,
    output logic [SIG_W-1:0]  lk_sig,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [SIG_W-1:0]  wr_sig
);
    localparam int ENTRIES = 1 << IDX_W;

    logic              vld_q [ENTRIES];
    logic [PAGE_W-1:0] tag_q [ENTRIES];
    logic [OFF_W-1:0]  off_q [ENTRIES];
    logic [SIG_W-1:0]  sig_q [ENTRIES];
    logic [IDX_W-1:0]  idx;

    // Look up the entry that belongs to the page.
    always_comb begin
        idx    = lk_page[IDX_W-1:0];
        lk_hit = vld_q[idx] && (tag_q[idx] == lk_page);
        lk_off = off_q[idx];
        lk_sig = sig_q[idx];
    end

    // Allocate or refresh the entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e] <= 1'b0;
                tag_q[e] <= '0;
                off_q[e] <= '0;
                sig_q[e] <= '0;
            end
        end else if (wr_en) begin
            vld_q[idx] <= 1'b1;
            tag_q[idx] <= lk_page;
            off_q[idx] <= wr_off;
            sig_q[idx] <= wr_sig;
        end
    end
endmodule

// File: rtl/spp_pattern_table.sv
// Pattern table: per signature index, several delta slots with counters
// and one signature counter. Training saturates by halving the whole entry.
// The read port returns the strongest slot of the entry it addresses.
// Assumes a slot counter never exceeds the signature counter of its entry.
module spp_pattern_table #(
    parameter int IDX_W  = 6,
    parameter int DW     = 7,
    parameter int NDELTA = 4,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tr_en,
    input  logic [IDX_W-1:0] tr_idx,
    input  logic [DW-1:0]    tr_delta,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_delta,
    output logic [CNT_W-1:0] rd_cnt_d,
    output logic [CNT_W-1:0] rd_cnt_s
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int SLOT_W  = (NDELTA > 1) ? $clog2(NDELTA) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [DW-1:0]    dlt_q  [ENTRIES][NDELTA];
    logic [CNT_W-1:0] dcnt_q [ENTRIES][NDELTA];
    logic [CNT_W-1:0] scnt_q [ENTRIES];

    logic              hit, sat;
    logic [SLOT_W-1:0] hit_slot, vic_slot, tgt_slot, best_slot;
    logic [CNT_W-1:0]  vic_cnt, best_cnt;
    logic [CNT_W-1:0]  dcnt_nx [NDELTA];
    logic [CNT_W-1:0]  scnt_nx;

    function automatic logic [CNT_W-1:0] halve(input logic [CNT_W-1:0] c, input logic h);
        return h ? (c >> 1) : c;
    endfunction

    // Find the matching slot, the victim slot and the saturation case.
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        vic_slot = '0;
        vic_cnt  = dcnt_q[tr_idx][0];
        for (int s = 0; s < NDELTA; s++) begin
            if (!hit && dcnt_q[tr_idx][s] != '0 && dlt_q[tr_idx][s] == tr_delta) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(s);
            end
            if (dcnt_q[tr_idx][s] < vic_cnt) begin
                vic_cnt  = dcnt_q[tr_idx][s];
                vic_slot = SLOT_W'(s);
            end
        end
        tgt_slot = hit ? hit_slot : vic_slot;
        sat      = (scnt_q[tr_idx] == CNT_MAX) || (hit && dcnt_q[tr_idx][hit_slot] == CNT_MAX);
    end

    // Next counter values of the trained entry.
    always_comb begin
        for (int s = 0; s < NDELTA; s++) begin
            if (SLOT_W'(s) == tgt_slot)
                dcnt_nx[s] = hit ? halve(dcnt_q[tr_idx][s], sat) + CNT_ONE : CNT_ONE;
            else
                dcnt_nx[s] = halve(dcnt_q[tr_idx][s], sat);
        end
        scnt_nx = halve(scnt_q[tr_idx], sat) + CNT_ONE;
    end

    // Store the trained entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                scnt_q[e] <= '0;
                for (int s = 0; s < NDELTA; s++) begin
                    dcnt_q[e][s] <= '0;
                    dlt_q[e][s]  <= '0;
                end
            end
        end else if (tr_en) begin
            scnt_q[tr_idx] <= scnt_nx;
            for (int s = 0; s < NDELTA; s++)
                dcnt_q[tr_idx][s] <= dcnt_nx[s];
            dlt_q[tr_idx][tgt_slot] <= tr_delta;
        end
    end

    // Pick the strongest slot of the entry being walked.
    always_comb begin
        best_slot = '0;
        best_cnt  = dcnt_q[rd_idx][0];
        for (int s = 1; s < NDELTA; s++) begin
            if (dcnt_q[rd_idx][s] > best_cnt) begin
                best_cnt  = dcnt_q[rd_idx][s];
                best_slot = SLOT_W'(s);
            end
        end
        rd_delta = dlt_q[rd_idx][best_slot];
        rd_cnt_d = best_cnt;
        rd_cnt_s = scnt_q[rd_idx];
        rd_valid = (best_cnt != '0);
    end

    AST_CNT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_cnt_d <= rd_cnt_s)); // R3
endmodule

// File: rtl/spp_ghr.sv
// Global history of walks that ran past a page edge: signature and the
// wrapped entry offset. Entries fill round-robin and are consumed on a match.
// Assumes a match is taken and a write is made in different cycles.
module spp_ghr #(
    parameter int SIG_W   = 12,
    parameter int OFF_W   = 6,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] mt_off,
    output logic             mt_hit,
    output logic [SIG_W-1:0] mt_sig,
    input  logic             mt_take,
    input  logic             wr_en,
    input  logic [SIG_W-1:0] wr_sig,
    input  logic [OFF_W-1:0] wr_off
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

    logic             vld_q [ENTRIES];
    logic [SIG_W-1:0] sig_q [ENTRIES];
    logic [OFF_W-1:0] off_q [ENTRIES];
    logic [PTR_W-1:0] ptr_q, mt_idx;

    // Lowest-index valid entry with the same offset.
    always_comb begin
        mt_hit = 1'b0;
        mt_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (!mt_hit && vld_q[e] && off_q[e] == mt_off) begin
                mt_hit = 1'b1;
                mt_idx = PTR_W'(e);
            end
        end
        mt_sig = sig_q[mt_idx];
    end

    // Record new crossings and retire consumed entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e] <= 1'b0;
                sig_q[e] <= '0;
                off_q[e] <= '0;
            end
        end else if (wr_en) begin
            vld_q[ptr_q] <= 1'b1;
            sig_q[ptr_q] <= wr_sig;
            off_q[ptr_q] <= wr_off;
            ptr_q        <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
        end else if (mt_take && mt_hit) begin
            vld_q[mt_idx] <= 1'b0;
        end
    end

    AST_GHR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mt_take && wr_en)); // R8
endmodule

// File: rtl/spp_prefetcher.sv
// Signature path lookahead prefetcher, top level.
// Takes one demand access when idle: trains the pattern table, updates the
// page signature, then walks the pattern table one step per cycle. Each step
// issues a prefetch or parks a page crossing in the global history.
// Assumes the consumer of pf_* may stall for any number of cycles.
module spp_prefetcher
    import spp_pkg::*;
#(
    parameter int PAGE_W      = 20,
    parameter int OFF_W       = 6,
    parameter int SIG_W       = 12,
    parameter int SIG_SHIFT   = 3,
    parameter int ST_IDX_W    = 4,
    parameter int PT_IDX_W    = 6,
    parameter int NDELTA      = 4,
    parameter int CNT_W       = 4,
    parameter int GHR_N       = 4,
    parameter int MAX_DEPTH   = 8,
    parameter int CONF_FRAC   = 8,
    parameter int CONF_THRESH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic [PAGE_W-1:0]       acc_page,
    input  logic [OFF_W-1:0]        acc_off,
    output logic                    acc_ready,
    output logic                    pf_valid,
    output logic [PAGE_W+OFF_W-1:0] pf_addr,
    input  logic                    pf_ready
);
    localparam int DW      = OFF_W + 1;
    localparam int CONF_W  = CONF_FRAC + 1;
    localparam int STEP_W  = CNT_W + CONF_FRAC;
    localparam int PROD_W  = STEP_W + CONF_W;
    localparam int DEPTH_W = $clog2(MAX_DEPTH + 1);
    localparam logic [CONF_W-1:0]  CONF_ONE   = CONF_W'(1 << CONF_FRAC);
    localparam logic [CONF_W-1:0]  CONF_MIN   = CONF_W'(CONF_THRESH);
    localparam logic [DEPTH_W-1:0] DEPTH_LAST = DEPTH_W'(MAX_DEPTH - 1);

    walk_state_e         state_q;
    logic [PAGE_W-1:0]   w_page_q;
    logic [SIG_W-1:0]    w_sig_q;
    logic [OFF_W-1:0]    w_off_q;
    logic [CONF_W-1:0]   w_conf_q;
    logic [DEPTH_W-1:0]  w_depth_q;

    logic                st_hit;
    logic [OFF_W-1:0]    st_off;
    logic [SIG_W-1:0]    st_sig;
    logic                ghr_hit;
    logic [SIG_W-1:0]    ghr_sig;
    logic                rd_valid;
    logic [DW-1:0]       rd_delta;
    logic [CNT_W-1:0]    rd_cnt_d, rd_cnt_s;

    logic                accept, train, ghr_take, ghr_wr, go, in_page;
    logic [DW-1:0]       acc_delta;
    logic [SIG_W-1:0]    start_sig, walk_sig_nx;
    logic [STEP_W-1:0]   step_conf;
    logic [PROD_W-1:0]   path_prod;
    logic [CONF_W-1:0]   new_conf;
    logic [DW:0]         tgt;

    function automatic logic [SIG_W-1:0] sig_next(input logic [SIG_W-1:0] s, input logic [DW-1:0] d);
        return (s << SIG_SHIFT) ^ SIG_W'(d);
    endfunction

    // Training side: delta of the access and the signature the walk starts from.
    always_comb begin
        accept    = acc_valid && (state_q == WALK_IDLE);
        acc_delta = DW'({1'b0, acc_off}) - DW'({1'b0, st_off});
        train     = accept && st_hit && (acc_delta != '0);
        ghr_take  = accept && !st_hit;
        if (st_hit)
            start_sig = (acc_delta != '0) ? sig_next(st_sig, acc_delta) : st_sig;
        else
            start_sig = ghr_hit ? ghr_sig : '0;
    end

    // Walk side: path confidence and target of the current step.
    always_comb begin
        step_conf   = {rd_cnt_d, {CONF_FRAC{1'b0}}} / STEP_W'((rd_cnt_s == '0) ? CNT_W'(1) : rd_cnt_s);
        path_prod   = PROD_W'(w_conf_q) * PROD_W'(step_conf);
        new_conf    = CONF_W'(path_prod >> CONF_FRAC);
        go          = (state_q == WALK_RUN) && rd_valid && (new_conf >= CONF_MIN);
        tgt         = {2'b00, w_off_q} + {rd_delta[DW-1], rd_delta};
        in_page     = (tgt[DW:OFF_W] == '0);
        walk_sig_nx = sig_next(w_sig_q, rd_delta);
        ghr_wr      = go && !in_page;
        pf_valid    = go && in_page;
        pf_addr     = {w_page_q, tgt[OFF_W-1:0]};
        acc_ready   = (state_q == WALK_IDLE);
    end

    // Walk control: start on an access, advance on each issued prefetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= WALK_IDLE;
            w_page_q  <= '0;
            w_sig_q   <= '0;
            w_off_q   <= '0;
            w_conf_q  <= '0;
            w_depth_q <= '0;
        end else if (state_q == WALK_IDLE) begin
            if (accept) begin
                state_q   <= WALK_RUN;
                w_page_q  <= acc_page;
                w_sig_q   <= start_sig;
                w_off_q   <= acc_off;
                w_conf_q  <= CONF_ONE;
                w_depth_q <= '0;
            end
        end else if (pf_valid) begin
            if (pf_ready) begin
                w_sig_q   <= walk_sig_nx;
                w_off_q   <= tgt[OFF_W-1:0];
                w_conf_q  <= new_conf;
                w_depth_q <= w_depth_q + 1'b1;
                if (w_depth_q == DEPTH_LAST)
                    state_q <= WALK_IDLE;
            end
        end else begin
            state_q <= WALK_IDLE;
        end
    end

    spp_sig_table #(
        .PAGE_W(PAGE_W), .OFF_W(OFF_W), .SIG_W(SIG_W), .IDX_W(ST_IDX_W)
    ) u_sig_table (
        .clk(clk), .rst_n(rst_n), .lk_page(acc_page), .lk_hit(st_hit),
        .lk_off(st_off), .lk_sig(st_sig), .wr_en(accept), .wr_off(acc_off),
        .wr_sig(start_sig)
    );

    spp_pattern_table #(
        .IDX_W(PT_IDX_W), .DW(DW), .NDELTA(NDELTA), .CNT_W(CNT_W)
    ) u_pattern_table (
        .clk(clk), .rst_n(rst_n), .tr_en(train), .tr_idx(st_sig[PT_IDX_W-1:0]),
        .tr_delta(acc_delta), .rd_idx(w_sig_q[PT_IDX_W-1:0]), .rd_valid(rd_valid),
        .rd_delta(rd_delta), .rd_cnt_d(rd_cnt_d), .rd_cnt_s(rd_cnt_s)
    );

    spp_ghr #(
        .SIG_W(SIG_W), .OFF_W(OFF_W), .ENTRIES(GHR_N)
    ) u_ghr (
        .clk(clk), .rst_n(rst_n), .mt_off(acc_off), .mt_hit(ghr_hit),
        .mt_sig(ghr_sig), .mt_take(ghr_take), .wr_en(ghr_wr),
        .wr_sig(walk_sig_nx), .wr_off(tgt[OFF_W-1:0])
    );

    AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr))); // R6
    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WALK_RUN) |-> (w_depth_q < DEPTH_W'(MAX_DEPTH))); // R7
    AST_CONF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WALK_RUN && w_depth_q != '0) |-> (w_conf_q >= CONF_MIN)); // R5
    AST_CROSS_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        ghr_wr |=> (acc_ready && !pf_valid)); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=> !acc_ready); // R10
endmodule

// File: tb/spp_prefetcher_tb.sv
module spp_prefetcher_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [19:0] acc_page = '0;
    logic [5:0]  acc_off = '0;
    logic        pf_ready = 1'b1;
    logic        acc_ready, pf_valid;
    logic [25:0] pf_addr;

    int n_checks = 0;
    int n_err = 0;
    bit bp_mode = 1'b0;

    // behavioural model state
    int st_v[16], st_tag[16], st_off[16], st_sig[16];
    int pt_d[64][4], pt_c[64][4], pt_s[64];
    int g_v[4], g_sig[4], g_off[4], g_ptr;
    int m_walk, m_page, m_sig, m_off, m_conf, m_depth;
    int m_rdy, m_pfv, m_addr, m_go, m_tgt, m_d, m_nc;

    spp_prefetcher dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .acc_off(acc_off), .acc_ready(acc_ready), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .pf_ready(pf_ready)
    );

    always #5 clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int snext(int s, int d);
        return ((s << 3) ^ d) & 4095;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) begin st_v[i] = 0; st_tag[i] = 0; st_off[i] = 0; st_sig[i] = 0; end
        for (int i = 0; i < 64; i++) begin
            pt_s[i] = 0;
            for (int s = 0; s < 4; s++) begin pt_c[i][s] = 0; pt_d[i][s] = 0; end
        end
        for (int i = 0; i < 4; i++) begin g_v[i] = 0; g_sig[i] = 0; g_off[i] = 0; end
        g_ptr = 0; m_walk = 0; m_page = 0; m_sig = 0; m_off = 0; m_conf = 0; m_depth = 0;
    endtask

    task automatic m_train(int idx, int d);
        int hs = -1;
        int vs = 0;
        int vc = pt_c[idx][0];
        bit sat;
        for (int s = 0; s < 4; s++) begin
            if (hs < 0 && pt_c[idx][s] != 0 && pt_d[idx][s] == d) hs = s;
            if (pt_c[idx][s] < vc) begin vc = pt_c[idx][s]; vs = s; end
        end
        sat = (pt_s[idx] == 15) || (hs >= 0 && pt_c[idx][hs] == 15);
        if (sat) begin
            for (int s = 0; s < 4; s++) pt_c[idx][s] = pt_c[idx][s] / 2;
            pt_s[idx] = pt_s[idx] / 2;
        end
        if (hs >= 0) pt_c[idx][hs]++;
        else begin pt_c[idx][vs] = 1; pt_d[idx][vs] = d; end
        pt_s[idx]++;
    endtask

    task automatic m_eval();
        int idx = m_sig % 64;
        int best = 0;
        int bc = pt_c[idx][0];
        int sd, step;
        for (int s = 1; s < 4; s++) if (pt_c[idx][s] > bc) begin bc = pt_c[idx][s]; best = s; end
        m_d  = pt_d[idx][best];
        sd   = (m_d >= 64) ? m_d - 128 : m_d;
        step = (bc != 0) ? (bc * 256) / pt_s[idx] : 0;
        m_nc = (m_conf * step) / 256;
        m_go = (m_walk != 0 && bc != 0 && m_nc >= 64) ? 1 : 0;
        m_tgt = m_off + sd;
        m_pfv = (m_go != 0 && m_tgt >= 0 && m_tgt < 64) ? 1 : 0;
        m_addr = m_page * 64 + m_tgt;
        m_rdy = (m_walk == 0) ? 1 : 0;
    endtask

    task automatic m_accept(int page, int off);
        int idx = page % 16;
        int sig = 0;
        int d;
        bit found = 0;
        if (st_v[idx] != 0 && st_tag[idx] == page) begin
            d = (off - st_off[idx]) & 127;
            if (d != 0) begin
                m_train(st_sig[idx] % 64, d);
                sig = snext(st_sig[idx], d);
            end else sig = st_sig[idx];
        end else begin
            for (int e = 0; e < 4; e++)
                if (!found && g_v[e] != 0 && g_off[e] == off) begin
                    found = 1; sig = g_sig[e]; g_v[e] = 0;
                end
        end
        st_v[idx] = 1; st_tag[idx] = page; st_off[idx] = off; st_sig[idx] = sig;
        m_walk = 1; m_page = page; m_sig = sig; m_off = off; m_conf = 256; m_depth = 0;
    endtask

    // Model advances on every clock edge with the inputs driven at the negedge.
    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            m_eval();
            if (m_walk == 0) begin
                if (acc_valid) m_accept(int'(acc_page), int'(acc_off));
            end else if (m_pfv != 0) begin
                if (pf_ready) begin
                    m_sig = snext(m_sig, m_d); m_off = m_tgt; m_conf = m_nc; m_depth++;
                    if (m_depth == 8) m_walk = 0;
                end
            end else if (m_go != 0) begin
                g_v[g_ptr] = 1; g_sig[g_ptr] = snext(m_sig, m_d); g_off[g_ptr] = m_tgt & 63;
                g_ptr = (g_ptr + 1) % 4; m_walk = 0;
            end else m_walk = 0;
        end
    end

    // Compare the outputs with the model every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            m_eval();
            check(int'(acc_ready) == m_rdy, "R10 acc_ready", int'(acc_ready), m_rdy);
            check(int'(pf_valid) == m_pfv, "R3 R5 pf_valid", int'(pf_valid), m_pfv);
            if (m_pfv != 0)
                check(int'(pf_addr) == m_addr, "R4 R6 pf_addr", int'(pf_addr), m_addr);
        end
    end

    task automatic do_access(int page, int off, output int npf, output int first);
        npf = 0; first = -1;
        while (!acc_ready) @(negedge clk);
        acc_valid = 1'b1; acc_page = 20'(page); acc_off = 6'(off); pf_ready = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        while (!acc_ready) begin
            pf_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
            if (pf_valid && pf_ready) begin
                if (npf == 0) first = int'(pf_addr);
                npf++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int npf, first;
        int pos[9], strd[9];
        int strides[5] = '{1, 2, 3, -1, 5};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(acc_ready == 1'b1, "R1 acc_ready after reset", int'(acc_ready), 1);
        check(pf_valid == 1'b0, "R1 pf_valid after reset", int'(pf_valid), 0);

        // stride +2 on page 5 converges to a fixed signature
        for (int o = 0; o <= 20; o += 2) do_access(5, o, npf, first);
        check(npf == 8, "R7 depth of steady stride walk", npf, 8);
        check(first == 5 * 64 + 22, "R4 R6 first lookahead target", first, 5 * 64 + 22);

        // repeated offset: no training, same walk
        do_access(5, 20, npf, first);
        check(npf == 8 && first == 5 * 64 + 22, "R2 repeat offset keeps signature", first, 5 * 64 + 22);

        // run up to the page end: last walk issues one prefetch then crosses
        for (int o = 22; o <= 60; o += 2) do_access(5, o, npf, first);
        check(npf == 1, "R8 walk stops at page edge", npf, 1);
        check(first == 5 * 64 + 62, "R8 last in-page target", first, 5 * 64 + 62);

        // new page at the wrapped offset resumes from the parked signature
        do_access(9, 0, npf, first);
        check(npf == 8, "R9 history-seeded walk depth", npf, 8);
        check(first == 9 * 64 + 2, "R9 history-seeded first target", first, 9 * 64 + 2);

        // stalls inside a walk must not lose requests
        bp_mode = 1'b1;
        do_access(9, 2, npf, first);
        check(npf == 8, "R6 all requests issued under stall", npf, 8);
        check(first == 9 * 64 + 4, "R6 first target under stall", first, 9 * 64 + 4);
        bp_mode = 1'b0;

        // random mix: strides, aliasing pages, stalls, saturation
        for (int k = 0; k < 9; k++) begin pos[k] = k * 7 % 64; strd[k] = strides[k % 5]; end
        for (int i = 0; i < 1500; i++) begin
            int k = $urandom_range(0, 8);
            int page = (k == 8) ? 116 : 100 + k;
            if ($urandom_range(0, 9) == 0) strd[k] = strides[$urandom_range(0, 4)];
            if ($urandom_range(0, 19) == 0) pos[k] = $urandom_range(0, 63);
            else pos[k] = (pos[k] + strd[k]) & 63;
            bp_mode = ($urandom_range(0, 1) == 1);
            do_access(page, pos[k], npf, first);
            check(npf <= 8, "R7 random walk depth", npf, 8);
        end
        bp_mode = 1'b0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule